// File: doc/BRIEF.md
# Lane-Partitioned Vector Multiplier

This block multiplies two wide vectors element by element. At run time a two-bit size code splits the vector into lanes: sixteen 8-bit lanes, eight 16-bit lanes or four 32-bit lanes at the default width of 128 bits. Every lane runs the same multiply in the same issue, each on its own operand slice. No partial product or carry passes from one lane into the next. Lane 0 sits in the least significant bits.

One control bit picks whether the operands are treated as two's-complement or as unsigned. A second control bit picks how the full product is brought back to lane width. Without it the product keeps only its low bits. With it the result clamps to the largest or smallest value the lane can hold.

The unit has two register stages and accepts one new operand pair on every clock. The size, sign and clamp controls travel down the pipe with their own data. Back-to-back issues can therefore use different lane sizes without draining the pipe.

Top module: `simd_mul_array`

## Requirements
- R1: While `rst_n` is low, and on the first edges after it rises, `out_valid` is 0 and `out_data` is all zeros.
- R2: An operand pair presented with `in_valid` high is captured at a rising edge. Its result and `out_valid` become visible after the next rising edge, two edges in all. `out_valid` stays low after only the capturing edge. A new pair may be presented on every cycle.
- R3: With `in_lane_size` = 2'b00 there are sixteen 8-bit lanes. Lane i occupies bits [8i+7:8i]. With `in_saturate` = 0, each lane returns the low 8 bits of its product.
- R4: With `in_lane_size` = 2'b01 there are eight 16-bit lanes. Lane i occupies bits [16i+15:16i].
- R5: With `in_lane_size` = 2'b10 there are four 32-bit lanes. Lane i occupies bits [32i+31:32i]. Code 2'b11 behaves exactly like 2'b10.
- R6: `in_signed` = 1 treats each lane operand as two's complement. `in_signed` = 0 treats it as unsigned.
- R7: With `in_saturate` = 1 and `in_signed` = 1, a product that does not fit becomes the lane's most positive value (0x7F..F) or most negative value (0x80..0), following the product's sign. A product that fits passes through unchanged.
- R8: With `in_saturate` = 1 and `in_signed` = 0, a product above the lane maximum becomes all ones.
- R9: No lane result depends on any bit of another lane's operands. An overflowing lane leaves its neighbours untouched.
- R10: The size, sign and clamp controls are taken per accepted input. Back-to-back issues with different settings each return the result of their own setting.
- R11: In a cycle with no accepted input, `out_valid` is 0 in the matching output cycle and `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair and controls are valid this cycle |
| in_a | input | 128 | First operand vector, lane 0 in the low bits |
| in_b | input | 128 | Second operand vector, lane 0 in the low bits |
| in_lane_size | input | 2 | 00: 8-bit, 01: 16-bit, 10 or 11: 32-bit lanes |
| in_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| in_saturate | input | 1 | 1: clamp to lane range, 0: keep low bits |
| out_valid | output | 1 | Result vector valid |
| out_data | output | 128 | Per-lane results, lane 0 in the low bits |

## Verification
Two things can happen in the same cycle: a result of one lane size leaves the output register while an input of another size is accepted and starts its first stage. The bench provokes this with a stream of table vectors issued on consecutive cycles, each one changing size, signedness or clamp mode. It judges every output against a lane-by-lane model evaluated under that vector's own settings. Directed single issues then pin each mode to hand-computed values and confirm that overflowing lanes leave their neighbours intact.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
   typedef enum logic [1:0] {
      LS_8   = 2'b00,
      LS_16  = 2'b01,
      LS_32  = 2'b10,
      LS_32X = 2'b11
   } lane_sz_e;

   localparam int NUM_SIZES = 3;
endpackage

// File: rtl/simd_lane_mul.sv
module simd_lane_mul #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chk_en,
   input  logic [LW-1:0] a,
   input  logic [LW-1:0] b,
   input  logic          sgn,
   input  logic          sat,
   output logic [LW-1:0] res
);
   localparam int PW = 2 * LW + 2;

   logic signed [LW:0]   ax, bx;
   logic signed [PW-1:0] axw, bxw, prod;
   logic                 ovf_s, ovf_u, ovf;
   logic [LW-1:0]        clampv;

   always_comb begin
      ax     = $signed({sgn & a[LW-1], a});
      bx     = $signed({sgn & b[LW-1], b});
      axw    = PW'(ax);
      bxw    = PW'(bx);
      prod   = axw * bxw;
      ovf_s  = !((&prod[PW-1:LW-1]) || !(|prod[PW-1:LW-1]));
      ovf_u  = |prod[PW-1:LW];
      ovf    = sgn ? ovf_s : ovf_u;
      if (!sgn)
         clampv = '1;
      else if (prod[PW-1])
         clampv = {1'b1, {(LW-1){1'b0}}};
      else
         clampv = {1'b0, {(LW-1){1'b1}}};
      res = (sat && ovf) ? clampv : prod[LW-1:0];
   end

   // R7: a clamped signed result keeps the sign of the true product
   p_sat_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && sat && sgn && prod != '0) |-> (res[LW-1] == prod[PW-1]));

   // R8: unsigned clamping never yields less than the wrapped value
   p_sat_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && sat && !sgn) |-> (res >= prod[LW-1:0]));
endmodule

// File: rtl/simd_lane_group.sv
module simd_lane_group #(
   parameter int VW = 128,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chk_en,
   input  logic [VW-1:0] a,
   input  logic [VW-1:0] b,
   input  logic          sgn,
   input  logic          sat,
   output logic [VW-1:0] res
);
   localparam int NL = VW / LW;

   if (VW % LW != 0) begin : g_bad_split
      $error("vector width must be a multiple of the lane width");
   end

   for (genvar l = 0; l < NL; l++) begin : g_lane
      simd_lane_mul #(.LW(LW)) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .chk_en(chk_en),
         .a     (a[l*LW +: LW]),
         .b     (b[l*LW +: LW]),
         .sgn   (sgn),
         .sat   (sat),
         .res   (res[l*LW +: LW])
      );
   end
endmodule

// File: rtl/simd_mul_array.sv
module simd_mul_array
   import simd_mul_pkg::*;
#(
   parameter int VW     = 128,
   parameter int LW_MIN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [VW-1:0] in_a,
   input  logic [VW-1:0] in_b,
   input  logic [1:0]    in_lane_size,
   input  logic          in_signed,
   input  logic          in_saturate,
   output logic          out_valid,
   output logic [VW-1:0] out_data
);
   localparam int LW_MAX = LW_MIN << (NUM_SIZES - 1);

   if (LW_MIN < 2 || VW % LW_MAX != 0) begin : g_bad_params
      $error("vector width must hold a whole number of widest lanes");
   end

   // stage 1: operand and control capture
   logic          s1_valid;
   logic [VW-1:0] s1_a, s1_b;
   lane_sz_e      s1_size;
   logic          s1_sgn, s1_sat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_a     <= '0;
         s1_b     <= '0;
         s1_size  <= LS_8;
         s1_sgn   <= 1'b0;
         s1_sat   <= 1'b0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_a    <= in_a;
            s1_b    <= in_b;
            s1_size <= lane_sz_e'(in_lane_size);
            s1_sgn  <= in_signed;
            s1_sat  <= in_saturate;
         end
      end
   end

   // one lane group per supported lane size
   logic [VW-1:0] grp_res [NUM_SIZES];

   for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_size
      localparam int GLW = LW_MIN << gi;
      simd_lane_group #(.VW(VW), .LW(GLW)) u_grp (
         .clk   (clk),
         .rst_n (rst_n),
         .chk_en(s1_valid),
         .a     (s1_a),
         .b     (s1_b),
         .sgn   (s1_sgn),
         .sat   (s1_sat),
         .res   (grp_res[gi])
      );
   end

   logic [VW-1:0] sel_res;

   always_comb begin
      case (s1_size)
         LS_8:    sel_res = grp_res[0];
         LS_16:   sel_res = grp_res[1];
         default: sel_res = grp_res[2];
      endcase
   end

   // stage 2: result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_data <= sel_res;
      end
   end

   // edges seen since reset, so that $past never reaches into reset
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   // R2: out_valid trails in_valid by exactly two edges
   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

   // R11: with nothing in stage 1 the output data holds
   p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_valid |=> $stable(out_data));
endmodule

// File: tb/tb_simd_mul_array.sv
module tb_simd_mul_array;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] in_a = '0, in_b = '0;
   logic [1:0]   in_lane_size = 2'b00;
   logic         in_signed = 1'b0, in_saturate = 1'b0;
   logic         out_valid;
   logic [127:0] out_data;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   simd_mul_array dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .in_lane_size(in_lane_size), .in_signed(in_signed), .in_saturate(in_saturate),
      .out_valid(out_valid), .out_data(out_data)
   );

   localparam int NV = 8;
   localparam logic [127:0] TA [NV] = '{
      {16{8'hFF}},
      128'h80_7F_FF_01_80_10_F0_0F_55_AA_12_34_C3_3C_7E_81,
      128'hFFFF_1234_8000_0101_ABCD_0002_7FFF_FFFE,
      128'h8000_7FFF_FFFF_0100_C000_4000_0003_FFF0,
      128'hFFFFFFFF_00010000_12345678_00000003,
      128'h80000000_7FFFFFFF_FFFFFFFE_00012345,
      128'hDEADBEEF_00000002_80000000_FFFFFFFF,
      128'h10_20_30_40_50_60_70_80_90_A0_B0_C0_D0_E0_F0_FF
   };
   localparam logic [127:0] TB [NV] = '{
      {16{8'hFF}},
      128'h80_80_02_FF_7F_10_10_11_02_03_04_05_06_07_7F_81,
      128'hFFFF_0010_8000_0100_0003_8000_0002_0002,
      128'h8000_7FFF_0002_0100_0004_0002_FFFF_0010,
      128'hFFFFFFFF_00010000_00000010_00000005,
      128'h80000000_00000002_00000003_FFFF0000,
      128'h00000011_40000000_80000000_FFFFFFFF,
      128'h10_08_06_04_04_03_03_02_02_02_02_02_02_02_02_02
   };
   localparam logic [1:0] TSZ [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b11, 2'b00};
   localparam logic       TSG [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic       TST [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

   function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b,
                                            input logic [1:0] sz, input logic sg, input logic st);
      int lw;
      logic [127:0] r;
      logic [31:0] ua, ub, mask;
      logic signed [67:0] x, y, p, mx, mn;
      lw   = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
      mask = (lw == 32) ? 32'hFFFF_FFFF : ((32'd1 << lw) - 32'd1);
      r    = '0;
      for (int i = 0; i < 128 / lw; i++) begin
         ua = 32'(a >> (i * lw)) & mask;
         ub = 32'(b >> (i * lw)) & mask;
         x  = 68'(ua);
         y  = 68'(ub);
         if (sg && ua[lw-1]) x = x - (68'sd1 <<< lw);
         if (sg && ub[lw-1]) y = y - (68'sd1 <<< lw);
         p = x * y;
         if (sg) begin
            mx = (68'sd1 <<< (lw - 1)) - 68'sd1;
            mn = -(68'sd1 <<< (lw - 1));
         end else begin
            mx = (68'sd1 <<< lw) - 68'sd1;
            mn = 68'sd0;
         end
         if (st && p > mx) p = mx;
         if (st && p < mn) p = mn;
         r = r | (128'(p[31:0] & mask) << (i * lw));
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_one(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                          input logic sg, input logic st, input logic [127:0] exp,
                          input string req);
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_lane_size = sz; in_signed = sg; in_saturate = st;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b0, "R2 early valid", 128'(out_valid), 128'd0);
      @(negedge clk);
      check(out_valid == 1'b1, "R2 valid", 128'(out_valid), 128'd1);
      check(out_data == exp, req, out_data, exp);
   endtask

   initial begin
      logic [127:0] exp_v [NV];
      logic [127:0] last;
      for (int i = 0; i < NV; i++) exp_v[i] = ref_mul(TA[i], TB[i], TSZ[i], TSG[i], TST[i]);

      // R1: reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R1 in reset", out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R1 after release", out_data, '0);

      // R10/R2: back-to-back stream, settings change on every issue
      for (int j = 0; j < NV + 2; j++) begin
         @(negedge clk);
         if (j >= 2) begin
            check(out_valid == 1'b1, "R2 stream valid", 128'(out_valid), 128'd1);
            check(out_data == exp_v[j-2], "R10 stream vector", out_data, exp_v[j-2]);
         end
         if (j < NV) begin
            in_valid = 1'b1; in_a = TA[j]; in_b = TB[j];
            in_lane_size = TSZ[j]; in_signed = TSG[j]; in_saturate = TST[j];
         end else begin
            in_valid = 1'b0;
         end
      end
      last = exp_v[NV-1];

      // R11: idle cycles, garbage on data inputs
      in_a = '1; in_b = '1; in_lane_size = 2'b01;
      repeat (3) begin
         @(negedge clk);
         check(out_valid == 1'b0, "R11 idle valid", 128'(out_valid), 128'd0);
         check(out_data == last, "R11 idle hold", out_data, last);
      end

      // R3 + R9: 8-bit wrap, lane 1 overflow stays in lane 1
      run_one(128'h1003, 128'h1005, 2'b00, 1'b0, 1'b0, 128'h000F, "R3 8-bit wrap R9");
      // R4: 16-bit lanes
      run_one(128'h0002_0003, 128'h0004_0005, 2'b01, 1'b0, 1'b0, 128'h0008_000F, "R4 16-bit");
      // R5 + R9: 32-bit product 2^32 wraps to 0 without touching lane 1
      run_one(128'h00000007_00010000, 128'h00000006_00010000, 2'b10, 1'b0, 1'b0,
              128'h0000002A_00000000, "R5 32-bit R9");
      run_one(128'h00000007_00010000, 128'h00000006_00010000, 2'b11, 1'b0, 1'b0,
              128'h0000002A_00000000, "R5 code 11");
      // R6: same bits, signed vs unsigned under clamping
      run_one(128'h00FF, 128'h0002, 2'b00, 1'b1, 1'b1, 128'h00FE, "R6 signed");
      run_one(128'h00FF, 128'h0002, 2'b00, 1'b0, 1'b1, 128'h00FF, "R6 unsigned");
      // R7: signed clamp both directions and passthrough
      run_one(128'h05_80_80, 128'h06_7F_80, 2'b00, 1'b1, 1'b1, 128'h1E_80_7F, "R7 signed clamp");
      // R8: unsigned clamp in 16-bit lanes
      run_one(128'h0003_0100, 128'h0004_0100, 2'b01, 1'b0, 1'b1, 128'h000C_FFFF, "R8 unsigned clamp");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule